// File: doc/BRIEF.md
# Self-Test and Heal Sequencer

This block steers a partitioned logic component through a two-stage self-test and, when a fault is found, through repair. It starts in a pseudo-random test phase and reads a packed 3-bit condition vector when the test engine reports completion. That vector holds the testing flag in bit 2, the located-subcomponent flag in bit 1 and the signature-mismatch flag in bit 0. A clean signature sends the block straight to normal operation. A mismatch sends it to deterministic per-subcomponent testing. A located fault sends it to healing.

During healing the block presents the index of one faulty subcomponent. A loader uses that index to pick the configuration slot of the replacement. The loader is outside this block and answers with a completion strobe. When several subcomponents are faulty, they are repaired one by one, lowest index first. Each repaired subcomponent keeps its input-redirect and output-select controls set from then on. These controls drive the demultiplexers and multiplexers that route its traffic through the replacement.

Top module: `heal_seq_ctrl`

## Requirements
- R1: While reset is low and in the first cycle after it is released, mode is 2'b00, heal_req is 0, and redirect_in and select_out are all zero.
- R2: In the random-test mode (2'b00), a cycle with rand_done high and cond_vec 3'b000 moves mode to 2'b11 (normal). With cond_vec 3'b101 it moves mode to 2'b01 (deterministic test). Any other vector keeps mode at 2'b00.
- R3: In the deterministic-test mode (2'b01), a cycle with det_done high, cond_vec 3'b111 and a nonzero fault_map moves mode to 2'b10 (heal). Any other condition on det_done moves mode to 2'b11.
- R4: While mode is 2'b10, heal_req is 1 and heal_idx is the lowest pending subcomponent. The redirect_in bit for that index is already set, and its select_out bit is still clear.
- R5: A heal_done pulse in mode 2'b10 sets select_out for the current index on the next cycle. On that same cycle heal_idx advances to the next higher pending index. Once no index remains pending, mode becomes 2'b11.
- R6: Mode 2'b11 is permanent until reset. Done strobes and condition vectors then have no effect, and redirect_in and select_out both hold the set of repaired subcomponents.
- R7: fault_map is sampled only on the det_done cycle. Later changes to it do not alter the healing order or the final select_out.
- R8: The two test modes and the heal mode hold, with heal_idx stable, for as long as their completion strobe stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cond_vec | input | 3 | {testing, located tag, signature-mismatch tag} |
| rand_done | input | 1 | Random-test phase finished |
| det_done | input | 1 | Deterministic-test phase finished |
| fault_map | input | NSUB | One bit per faulty subcomponent, valid with det_done |
| heal_done | input | 1 | Replacement for heal_idx is loaded |
| mode | output | 2 | 00 random test, 01 deterministic test, 10 heal, 11 normal |
| heal_req | output | 1 | Healing in progress |
| heal_idx | output | $clog2(NSUB) | Subcomponent being repaired |
| redirect_in | output | NSUB | Per-subcomponent input demux control |
| select_out | output | NSUB | Per-subcomponent output mux control |

## Verification
Two things fall in the same clock edge when a heal_done pulse arrives with more subcomponents still pending. The select_out bit of the repaired index latches, and heal_idx moves to the next index in ascending order. The bench provokes this by sweeping every nonzero fault_map and varying how long each heal takes. After each pulse it checks that select_out gained exactly that bit and that heal_idx and redirect_in moved to the next pending index. It also checks that the final pulse moves mode to normal, not to another heal.

// File: rtl/heal_seq_ctrl.sv
module heal_seq_ctrl #(
  parameter int NSUB = 4,
  localparam int IW = (NSUB > 1) ? $clog2(NSUB) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      cond_vec,
  input  logic            rand_done,
  input  logic            det_done,
  input  logic [NSUB-1:0] fault_map,
  input  logic            heal_done,
  output logic [1:0]      mode,
  output logic            heal_req,
  output logic [IW-1:0]   heal_idx,
  output logic [NSUB-1:0] redirect_in,
  output logic [NSUB-1:0] select_out
);

  typedef enum logic [1:0] {
    ST_RAND = 2'b00,
    ST_DET  = 2'b01,
    ST_HEAL = 2'b10,
    ST_NORM = 2'b11
  } st_t;

  st_t st, st_nx;
  logic [NSUB-1:0] pend, pend_nx, fixed, fixed_nx;
  logic [IW-1:0]   cur;
  logic [NSUB-1:0] cur_oh, pend_left;

  always_comb begin
    cur = '0;
    for (int i = NSUB - 1; i >= 0; i--)
      if (pend[i]) cur = IW'(i);
  end

  assign cur_oh    = NSUB'(1) << cur;
  assign pend_left = pend & ~cur_oh;

  always_comb begin
    st_nx    = st;
    pend_nx  = pend;
    fixed_nx = fixed;
    case (st)
      ST_RAND:
        if (rand_done) begin
          if (cond_vec == 3'b000)      st_nx = ST_NORM;
          else if (cond_vec == 3'b101) st_nx = ST_DET;
        end
      ST_DET:
        if (det_done) begin
          if (cond_vec == 3'b111 && |fault_map) begin
            st_nx   = ST_HEAL;
            pend_nx = fault_map;
          end else begin
            st_nx = ST_NORM;
          end
        end
      ST_HEAL:
        if (heal_done) begin
          fixed_nx = fixed | cur_oh;
          pend_nx  = pend_left;
          if (pend_left == '0) st_nx = ST_NORM;
        end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= ST_RAND;
      pend  <= '0;
      fixed <= '0;
    end else begin
      st    <= st_nx;
      pend  <= pend_nx;
      fixed <= fixed_nx;
    end
  end

  assign mode        = st;
  assign heal_req    = (st == ST_HEAL);
  assign heal_idx    = cur;
  assign redirect_in = fixed | (heal_req ? cur_oh : '0);
  assign select_out  = fixed;

endmodule

// File: rtl/heal_seq_ctrl_chk.sv
module heal_seq_ctrl_chk #(
  parameter int NSUB = 4,
  localparam int IW = (NSUB > 1) ? $clog2(NSUB) : 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            rand_done,
  input logic            det_done,
  input logic            heal_done,
  input logic [1:0]      mode,
  input logic            heal_req,
  input logic [IW-1:0]   heal_idx,
  input logic [NSUB-1:0] redirect_in,
  input logic [NSUB-1:0] select_out
);

  assert_normal_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'b11 |=> mode == 2'b11 && $stable(select_out));

  assert_rand_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'b00 && !rand_done |=> mode == 2'b00);

  assert_det_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'b01 && !det_done |=> mode == 2'b01);

  assert_heal_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'b10 && !heal_done |=> mode == 2'b10 && $stable(heal_idx));

  assert_heal_route_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'b10 |-> heal_req && redirect_in[heal_idx] && !select_out[heal_idx]);

  assert_latch_select_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'b10 && heal_done |=> select_out[$past(heal_idx)]);

  assert_select_grows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (select_out & $past(select_out)) == $past(select_out));

endmodule

bind heal_seq_ctrl heal_seq_ctrl_chk #(.NSUB(NSUB)) u_chk (.*);

// File: tb/test_heal_seq_ctrl.sv
`timescale 1ns/1ps
module test_heal_seq_ctrl;
  localparam int NSUB = 4;
  localparam int IW = 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n;
  logic [2:0] cond_vec;
  logic rand_done, det_done, heal_done;
  logic [NSUB-1:0] fault_map;
  logic [1:0] mode;
  logic heal_req;
  logic [IW-1:0] heal_idx;
  logic [NSUB-1:0] redirect_in, select_out;

  int checks = 0;
  int errors = 0;

  heal_seq_ctrl #(.NSUB(NSUB)) i_heal_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .cond_vec(cond_vec), .rand_done(rand_done),
    .det_done(det_done), .fault_map(fault_map), .heal_done(heal_done),
    .mode(mode), .heal_req(heal_req), .heal_idx(heal_idx),
    .redirect_in(redirect_in), .select_out(select_out));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cond_vec = '0; rand_done = 0; det_done = 0; heal_done = 0; fault_map = '0;
    tick(); tick();
    chk("R1 mode in reset", mode, 2'b00);
    chk("R1 heal_req in reset", heal_req, 0);
    chk("R1 redirect in reset", redirect_in, 0);
    chk("R1 select in reset", select_out, 0);
    rst_n = 1'b1;
    tick();
    chk("R1 mode after reset", mode, 2'b00);
  endtask

  task automatic pulse_rand(input logic [2:0] v);
    cond_vec = v; rand_done = 1; tick(); rand_done = 0;
  endtask

  task automatic pulse_det(input logic [2:0] v, input logic [NSUB-1:0] m);
    cond_vec = v; fault_map = m; det_done = 1; tick(); det_done = 0;
  endtask

  task automatic check_normal_hold(input logic [NSUB-1:0] m);
    pulse_rand(3'b101);
    pulse_det(3'b111, 4'hF);
    heal_done = 1; tick(); heal_done = 0;
    chk("R6 mode stays normal", mode, 2'b11);
    chk("R6 select held", select_out, m);
    chk("R6 redirect held", redirect_in, m);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    for (int k = 0; k < 3; k++) begin tick(); chk("R8 random hold", mode, 2'b00); end
    pulse_rand(3'b000);
    chk("R2 clean vector to normal", mode, 2'b11);
    chk("R6 no redirect fault-free", select_out, 0);
    check_normal_hold(4'h0);

    do_reset();
    pulse_rand(3'b001);
    chk("R2 other vector stays random", mode, 2'b00);
    pulse_rand(3'b100);
    chk("R2 other vector stays random", mode, 2'b00);
    pulse_rand(3'b101);
    chk("R2 mismatch vector to det", mode, 2'b01);
    pulse_det(3'b101, 4'h3);
    chk("R3 no located tag to normal", mode, 2'b11);
    chk("R3 nothing repaired", select_out, 0);

    do_reset();
    pulse_rand(3'b101);
    pulse_det(3'b111, 4'h0);
    chk("R3 empty map to normal", mode, 2'b11);

    for (int m = 1; m < (1 << NSUB); m++) begin
      logic [NSUB-1:0] acc;
      acc = '0;
      do_reset();
      pulse_rand(3'b101);
      for (int k = 0; k < 2; k++) begin tick(); chk("R8 det hold", mode, 2'b01); end
      pulse_det(3'b111, NSUB'(m));
      fault_map = ~NSUB'(m);
      for (int i = 0; i < NSUB; i++) begin
        if (m[i]) begin
          chk("R4 heal mode", mode, 2'b10);
          chk("R4 heal_req", heal_req, 1);
          chk("R4 R5 R7 heal_idx ascending", heal_idx, i);
          chk("R4 redirect ahead of select", redirect_in, acc | (NSUB'(1) << i));
          chk("R5 select so far", select_out, acc);
          for (int d = 0; d < (i + m) % 3; d++) begin
            tick();
            chk("R8 heal hold idx", heal_idx, i);
            chk("R8 heal hold mode", mode, 2'b10);
          end
          heal_done = 1; tick(); heal_done = 0;
          acc = acc | (NSUB'(1) << i);
          chk("R5 select latched", select_out, acc);
        end
      end
      chk("R5 all healed to normal", mode, 2'b11);
      chk("R7 final select matches captured map", select_out, m);
      chk("R5 heal_req low", heal_req, 0);
      check_normal_hold(NSUB'(m));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule